// File: doc/BRIEF.md
# Fragmented Message Receiver

This block drains a message from a peer's slot buffer, one 32-bit slot at a time. Every fragment begins with a header slot. The header carries the payload length in bytes and a flag that marks the final fragment. The receiver waits until the body slots are present, then streams the payload out one byte per cycle. It keeps going fragment after fragment until it has taken in a fragment marked final, then reports the total length of the message.

Each reception begins with a `start` pulse. The receiver first waits for the peer to declare itself ready, and it retries that wait a bounded number of times. Once the peer is ready, any fault ends the reception with an error code: an oversize fragment, a slot that does not arrive in time, the peer dropping readiness, or an empty fragment that is not final.

When a non-final fragment has been consumed and the peer buffer is empty, the receiver pulses a doorbell to ask the peer for the next fragment.

Top module: `msg_rx_top`

## Requirements
- R1: In the header wait, the receiver pops a slot only when `fill_cnt` is non-zero and takes that slot as the header. The length is header bits 24:16 and the final-fragment flag is bit 31. All other header bits have no effect on the result.
- R2: For a fragment of length L, the receiver waits until `fill_cnt` >= ceil(L/4) and then pops exactly ceil(L/4) slots. It emits exactly L bytes on `out_vld`/`out_byte`, low byte of each slot first (bits 7:0, then 15:8, and so on). From the last slot it keeps only the low L mod 4 bytes when that value is non-zero.
- R3: A fragment whose length exceeds CAP_BYTES minus the bytes already taken in this message ends reception with `err_code` 3. No body slot of that fragment is popped.
- R4: The receiver samples `peer_rdy` after all whole body words of a fragment have been popped. If `peer_rdy` is low at that point, reception ends with `err_code` 4.
- R5: After a non-final fragment, `ring` pulses for exactly one cycle if `fill_cnt` is zero, and it stays low if slots remain.
- R6: `done` pulses for one cycle only after a final fragment. While `done` is high, `len_out` equals the sum of all fragment lengths.
- R7: A zero-length fragment pulses `warn`. If it is final, the message completes; if it is not final, reception ends with `err_code` 5.
- R8: The peer-ready wait lasts up to WAIT_CYC cycles and is retried, for at most RETRIES windows in total. If all windows expire, `err_code` is 1 and the error comes no earlier than RETRIES*WAIT_CYC cycles after `start`. If the peer becomes ready during any window, reception proceeds.
- R9: If the header slot or the body slots are not all present within WAIT_CYC cycles, reception ends with `err_code` 2.
- R10: After reset, `busy`, `out_vld`, `slot_pop`, `ring`, `done` and `err` are all low.
- R11: Each accepted `start` ends in exactly one one-cycle pulse of either `done` or `err`, with a non-zero `err_code` on `err`. `busy` is high from the start until that pulse and low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin reception (sampled when idle) |
| peer_rdy | input | 1 | Peer readiness |
| fill_cnt | input | FILL_W | Number of filled slots in the peer buffer |
| slot_data | input | 32 | Oldest filled slot (show-ahead) |
| slot_pop | output | 1 | Consume the oldest slot this cycle |
| ring | output | 1 | Doorbell pulse requesting more data |
| out_vld | output | 1 | Payload byte valid |
| out_byte | output | 8 | Payload byte |
| done | output | 1 | End-of-message strobe |
| err | output | 1 | Reception failed strobe |
| err_code | output | 3 | Failure cause: 1 not ready, 2 timeout, 3 oversize, 4 peer lost, 5 empty non-final |
| len_out | output | $clog2(CAP_BYTES+1) | Total message length |
| warn | output | 1 | Zero-length fragment seen |
| busy | output | 1 | Reception in progress |

## Verification
The assertions assume that the peer buffer behaves as a show-ahead queue. `fill_cnt` must fall by one on the edge after each pop and never rise above what the peer wrote, and `slot_data` must be valid whenever `fill_cnt` is non-zero. The bench builds that buffer as a model queue whose read pointer moves only on `slot_pop`, and it keeps every `start` inside the idle window. Lengths are swept across the whole capacity and past it, with random filler in the unused header bits.

// File: rtl/msg_rx_pkg.sv
package msg_rx_pkg;
  localparam int HDR_LEN_LSB = 16;
  localparam int HDR_LEN_W   = 9;
  localparam int HDR_FIN_BIT = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RDYW, ST_HDRW, ST_CHK, ST_BODYW,
    ST_WORD, ST_EMIT, ST_FEND, ST_FIN, ST_ERR
  } rx_state_e;

  typedef enum logic [2:0] {
    RX_NONE     = 3'd0,
    RX_NOTRDY   = 3'd1,
    RX_TIMEOUT  = 3'd2,
    RX_OVERSIZE = 3'd3,
    RX_PEERLOST = 3'd4,
    RX_ZEROFRAG = 3'd5
  } rx_err_e;
endpackage

// File: rtl/msg_rx_hdr.sv
module msg_rx_hdr
  import msg_rx_pkg::*;
(
  input  logic [31:0]          hdr,
  output logic [HDR_LEN_W-1:0] len,
  output logic                 fin,
  output logic [6:0]           whole,
  output logic [1:0]           rem,
  output logic [7:0]           need
);
  always_comb begin
    len   = hdr[HDR_LEN_LSB +: HDR_LEN_W];
    fin   = hdr[HDR_FIN_BIT];
    whole = len[8:2];
    rem   = len[1:0];
    need  = {1'b0, whole} + {7'd0, (rem != 2'd0)};
  end
endmodule

// File: rtl/msg_rx_bytesel.sv
module msg_rx_bytesel (
  input  logic [31:0] word,
  input  logic [1:0]  idx,
  output logic [7:0]  byte_o
);
  logic [7:0] lane [4];
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = word[g*8 +: 8];
  end
  assign byte_o = lane[idx];
endmodule

// File: rtl/msg_rx_timer.sv
module msg_rx_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/msg_rx_top.sv
module msg_rx_top
  import msg_rx_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter int WAIT_CYC  = 1024,
  parameter int RETRIES   = 5,
  parameter int FILL_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           peer_rdy,
  input  logic [FILL_W-1:0]              fill_cnt,
  input  logic [31:0]                    slot_data,
  output logic                           slot_pop,
  output logic                           ring,
  output logic                           out_vld,
  output logic [7:0]                     out_byte,
  output logic                           done,
  output logic                           err,
  output logic [2:0]                     err_code,
  output logic [$clog2(CAP_BYTES+1)-1:0] len_out,
  output logic                           warn,
  output logic                           busy
);
  localparam int TOT_W = $clog2(CAP_BYTES + 1);
  localparam int TRY_W = $clog2(RETRIES + 1);
  localparam int CMPW  = ((FILL_W > TOT_W) ? FILL_W : TOT_W) + 11;

  rx_state_e          st_q, st_d;
  logic [31:0]        hdr_q, hdr_d, word_q, word_d;
  logic [6:0]         wl_q, wl_d;
  logic [1:0]         idx_q, idx_d, lastidx_q, lastidx_d;
  logic               tail_q, tail_d;
  logic [TOT_W-1:0]   total_q, total_d;
  logic [TRY_W-1:0]   tries_q, tries_d;
  rx_err_e            code_q, code_d;
  logic               tmr_retry, tmr_exp;

  logic [HDR_LEN_W-1:0] f_len;
  logic                 f_fin;
  logic [6:0]           f_whole;
  logic [1:0]           f_rem;
  logic [7:0]           f_need;
  logic [CMPW-1:0]      room;
  logic                 too_big;

  msg_rx_hdr u_hdr (
    .hdr(hdr_q), .len(f_len), .fin(f_fin),
    .whole(f_whole), .rem(f_rem), .need(f_need)
  );

  msg_rx_bytesel u_sel (.word(word_q), .idx(idx_q), .byte_o(out_byte));

  msg_rx_timer #(.LIMIT(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr((st_d != st_q) || tmr_retry),
    .expired(tmr_exp)
  );

  assign room    = CMPW'(CAP_BYTES) - CMPW'(total_q);
  assign too_big = CMPW'(f_len) > room;

  always_comb begin
    st_d = st_q;       hdr_d = hdr_q;   word_d = word_q;
    wl_d = wl_q;       idx_d = idx_q;   lastidx_d = lastidx_q;
    tail_d = tail_q;   total_d = total_q;
    tries_d = tries_q; code_d = code_q;
    tmr_retry = 1'b0;  slot_pop = 1'b0; ring = 1'b0;
    out_vld = 1'b0;    done = 1'b0;     err = 1'b0;  warn = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        tries_d = '0; total_d = '0; st_d = ST_RDYW;
      end
      ST_RDYW: begin
        if (peer_rdy) st_d = ST_HDRW;
        else if (tmr_exp) begin
          if (tries_q == TRY_W'(RETRIES - 1)) begin
            code_d = RX_NOTRDY; st_d = ST_ERR;
          end else begin
            tries_d = tries_q + 1'b1; tmr_retry = 1'b1;
          end
        end
      end
      ST_HDRW: begin
        if (fill_cnt != '0) begin
          slot_pop = 1'b1; hdr_d = slot_data; st_d = ST_CHK;
        end else if (tmr_exp) begin
          code_d = RX_TIMEOUT; st_d = ST_ERR;
        end
      end
      ST_CHK: begin
        wl_d = f_whole;
        if (too_big) begin
          code_d = RX_OVERSIZE; st_d = ST_ERR;
        end else if (f_len == '0) begin
          warn = 1'b1;
          if (f_fin) st_d = ST_FIN;
          else begin code_d = RX_ZEROFRAG; st_d = ST_ERR; end
        end else st_d = ST_BODYW;
      end
      ST_BODYW: begin
        if (CMPW'(fill_cnt) >= CMPW'(f_need)) st_d = ST_WORD;
        else if (tmr_exp) begin
          code_d = RX_TIMEOUT; st_d = ST_ERR;
        end
      end
      ST_WORD: begin
        if (wl_q != '0) begin
          slot_pop = 1'b1; word_d = slot_data; wl_d = wl_q - 1'b1;
          idx_d = '0; lastidx_d = 2'd3; tail_d = 1'b0; st_d = ST_EMIT;
        end else if (!peer_rdy) begin
          code_d = RX_PEERLOST; st_d = ST_ERR;
        end else if (f_rem != '0) begin
          slot_pop = 1'b1; word_d = slot_data;
          idx_d = '0; lastidx_d = f_rem - 1'b1; tail_d = 1'b1; st_d = ST_EMIT;
        end else st_d = ST_FEND;
      end
      ST_EMIT: begin
        out_vld = 1'b1;
        idx_d = idx_q + 1'b1;
        if (idx_q == lastidx_q) st_d = tail_q ? ST_FEND : ST_WORD;
      end
      ST_FEND: begin
        total_d = total_q + TOT_W'(f_len);
        if (f_fin) st_d = ST_FIN;
        else begin
          ring = (fill_cnt == '0);
          st_d = ST_HDRW;
        end
      end
      ST_FIN: begin done = 1'b1; st_d = ST_IDLE; end
      ST_ERR: begin err = 1'b1;  st_d = ST_IDLE; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  hdr_q <= '0;   word_q <= '0;
      wl_q <= '0;       idx_q <= '0;   lastidx_q <= '0;
      tail_q <= 1'b0;   total_q <= '0; tries_q <= '0;
      code_q <= RX_NONE;
    end else begin
      st_q <= st_d;     hdr_q <= hdr_d; word_q <= word_d;
      wl_q <= wl_d;     idx_q <= idx_d; lastidx_q <= lastidx_d;
      tail_q <= tail_d; total_q <= total_d; tries_q <= tries_d;
      code_q <= code_d;
    end
  end

  assign err_code = err ? code_q : 3'd0;
  assign len_out  = total_q;
  assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/msg_rx_chk.sv
module msg_rx_chk #(
  parameter int CAP_BYTES = 256,
  parameter int FILL_W    = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [FILL_W-1:0]              fill_cnt,
  input logic                           slot_pop,
  input logic                           ring,
  input logic                           out_vld,
  input logic                           done,
  input logic                           err,
  input logic [2:0]                     err_code,
  input logic [$clog2(CAP_BYTES+1)-1:0] len_out,
  input logic                           busy
);
  assert_pop_needs_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pop |-> fill_cnt != '0);
  assert_vld_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> busy);
  assert_len_within_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(len_out) <= CAP_BYTES);
  assert_ring_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring |=> !ring);
  assert_ring_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring |-> fill_cnt == '0);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_err_coded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> err_code != 3'd0);
  assert_idle_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !busy);
endmodule

bind msg_rx_top msg_rx_chk #(.CAP_BYTES(CAP_BYTES), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .slot_pop(slot_pop),
  .ring(ring), .out_vld(out_vld), .done(done), .err(err),
  .err_code(err_code), .len_out(len_out), .busy(busy)
);

// File: tb/test_msg_rx_top.sv
module test_msg_rx_top;
  localparam int CAP = 32;
  localparam int TO  = 16;
  localparam int RT  = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, peer_rdy = 1'b1;
  logic [7:0] fill_cnt;
  logic [31:0] slot_data;
  logic slot_pop, ring, out_vld, done, err, warn, busy;
  logic [7:0] out_byte;
  logic [2:0] err_code;
  logic [5:0] len_out;

  always #2.5 clk = ~clk;

  msg_rx_top #(.CAP_BYTES(CAP), .WAIT_CYC(TO), .RETRIES(RT), .FILL_W(8)) i_msg_rx_top (
    .clk(clk), .rst_n(rst_n), .start(start), .peer_rdy(peer_rdy),
    .fill_cnt(fill_cnt), .slot_data(slot_data), .slot_pop(slot_pop),
    .ring(ring), .out_vld(out_vld), .out_byte(out_byte), .done(done),
    .err(err), .err_code(err_code), .len_out(len_out), .warn(warn), .busy(busy)
  );

  // peer buffer model
  logic [31:0] pmem [64];
  int wp = 0, rp = 0;
  assign fill_cnt  = 8'(wp - rp);
  assign slot_data = pmem[rp & 63];
  always @(posedge clk) if (slot_pop) rp <= rp + 1;

  // output monitor
  logic [7:0] cap [256];
  int ncap = 0, ndone = 0, nerr = 0, nring = 0, nwarn = 0;
  int last_len = 0, last_code = 0, cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (out_vld) begin cap[ncap & 255] <= out_byte; ncap <= ncap + 1; end
    if (done) begin ndone <= ndone + 1; last_len <= int'(len_out); end
    if (err)  begin nerr <= nerr + 1; last_code <= int'(err_code); end
    if (ring) nring <= nring + 1;
    if (warn) nwarn <= nwarn + 1;
  end

  int checks = 0, errors = 0, extra = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic push(input logic [31:0] w);
    pmem[wp & 63] = w; wp = wp + 1;
  endtask

  task automatic push_frag(input int len, input bit fin, input int base, input bit body);
    logic [31:0] h, w;
    extra = extra * 1103 + 12345;
    h = 32'(extra) & 32'h7E00_FFFF;
    h[31] = fin; h[24:16] = 9'(len);
    push(h);
    if (body)
      for (int i = 0; i < (len + 3) / 4; i++) begin
        for (int b = 0; b < 4; b++)
          w[b*8 +: 8] = (i*4 + b < len) ? pat(base + i*4 + b) : 8'hEE;
        push(w);
      end
  endtask

  task automatic clr_counts();
    step(); ncap = 0; ndone = 0; nerr = 0; nring = 0; nwarn = 0;
  endtask

  task automatic kick();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic wait_end();
    int n0 = ndone + nerr;
    for (int i = 0; i < 2000; i++) begin
      if (ndone + nerr != n0) return;
      step();
    end
    chk(1'b0, "watchdog R11", 0, 1);
  endtask

  task automatic chk_bytes(input int n, input string tag);
    bit ok = (ncap == n);
    for (int k = 0; k < n; k++) if (cap[k] !== pat(k)) ok = 0;
    chk(ok, tag, ncap, n);
  endtask

  initial begin
    repeat (3) step();
    chk(!busy && !out_vld && !slot_pop && !ring && !done && !err, "R10 reset idle", int'(busy), 0);
    rst_n = 1'b1;
    step();

    // sweep single final fragment across and past capacity
    for (int L = 0; L <= CAP + 8; L++) begin
      clr_counts();
      push_frag(L, 1'b1, 0, 1'b1);
      kick(); wait_end(); step();
      if (L <= CAP) begin
        chk(ndone == 1 && nerr == 0, "R6 done single frag", ndone, 1);
        chk(last_len == L, "R6 length", last_len, L);
        chk_bytes(L, "R2 bytes single frag");
        chk(fill_cnt == 0, "R2 slots consumed", int'(fill_cnt), 0);
        if (L == 0) chk(nwarn == 1, "R7 zero final warns", nwarn, 1);
      end else begin
        chk(nerr == 1 && last_code == 3, "R3 oversize", last_code, 3);
        chk(int'(fill_cnt) == (L + 3) / 4, "R3 no body pop", int'(fill_cnt), (L + 3) / 4);
        chk(ncap == 0, "R3 no bytes", ncap, 0);
        wp = rp;
      end
      chk(!busy, "R11 idle after", int'(busy), 0);
    end

    // three preloaded fragments filling capacity, no doorbell
    clr_counts();
    push_frag(10, 1'b0, 0, 1'b1); push_frag(10, 1'b0, 10, 1'b1); push_frag(12, 1'b1, 20, 1'b1);
    kick(); wait_end(); step();
    chk(last_len == 32 && ndone == 1, "R6 sum of fragments", last_len, 32);
    chk_bytes(32, "R2 bytes multi frag");
    chk(nring == 0, "R5 no ring while slots remain", nring, 0);

    // doorbell when buffer drained mid-message
    clr_counts();
    push_frag(6, 1'b0, 0, 1'b1);
    kick();
    for (int i = 0; i < 200 && nring == 0; i++) step();
    chk(nring == 1 && ndone == 0, "R5 ring on empty", nring, 1);
    push_frag(5, 1'b1, 6, 1'b1);
    wait_end(); step();
    chk(last_len == 11 && nring == 1, "R5 message after ring", last_len, 11);
    chk_bytes(11, "R2 bytes after ring");

    // cumulative oversize
    clr_counts();
    push_frag(20, 1'b0, 0, 1'b1); push_frag(13, 1'b1, 20, 1'b1);
    kick(); wait_end(); step();
    chk(last_code == 3 && ndone == 0, "R3 cumulative oversize", last_code, 3);
    chk(ncap == 20, "R3 first frag bytes", ncap, 20);
    wp = rp;

    // zero-length non-final
    clr_counts();
    push_frag(0, 1'b0, 0, 1'b1);
    kick(); wait_end(); step();
    chk(last_code == 5 && nwarn == 1, "R7 zero non-final error", last_code, 5);

    // header timeout and body timeout
    clr_counts();
    kick(); wait_end(); step();
    chk(last_code == 2, "R9 header timeout", last_code, 2);
    clr_counts();
    push_frag(8, 1'b1, 0, 1'b0);
    kick(); wait_end(); step();
    chk(last_code == 2 && ncap == 0, "R9 body timeout", last_code, 2);
    wp = rp;

    // peer lost after whole words
    clr_counts();
    push_frag(6, 1'b1, 0, 1'b1);
    kick();
    for (int i = 0; i < 50 && rp < wp - 2; i++) step();
    peer_rdy = 1'b0;
    wait_end(); step();
    chk(last_code == 4 && ndone == 0, "R4 peer lost", last_code, 4);
    chk(ncap == 4, "R4 whole word bytes only", ncap, 4);
    wp = rp;

    // ready never arrives
    clr_counts();
    begin
      int t0 = cyc;
      kick(); wait_end();
      chk(last_code == 1, "R8 not ready error", last_code, 1);
      chk(cyc - t0 >= RT * TO, "R8 all windows used", cyc - t0, RT * TO);
    end
    step();

    // ready arrives during third window
    clr_counts();
    push_frag(3, 1'b1, 0, 1'b1);
    kick();
    repeat (2 * TO + 5) step();
    chk(ndone == 0 && nerr == 0, "R8 still waiting", nerr, 0);
    peer_rdy = 1'b1;
    wait_end(); step();
    chk(ndone == 1 && last_len == 3, "R8 retry success", last_len, 3);
    chk_bytes(3, "R1 header filler ignored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule